// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Status Flags

This block is the data-path ALU of a small accumulator machine. It combines an accumulator operand and a second operand under a four-bit operation code and returns the result in the same cycle. The operations are binary and decimal-friendly addition and subtraction (with and without the stored carry), increment, decrement, bitwise AND, OR, XOR, complement of the accumulator, and four rotates.

Alongside the result the block computes five status flags: sign, zero, even parity, carry (a borrow on subtraction) and the nibble auxiliary carry that a decimal-adjust step needs. The flags are held in a register inside the block. On a rising clock edge with the flag-write enable high, the flags that the current operation affects take their new values and the rest keep theirs. The add-with-carry, subtract-with-borrow and rotate-through-carry operations read the stored carry flag.

Top module: `byte_alu_top`

## Requirements
- R1: Opcode 0 (add) gives acc+opb and opcode 1 (add with carry) gives acc+opb+CY, both modulo 256. The carry flag takes the carry out of bit 7.
- R2: Opcode 2 (subtract) gives acc-opb and opcode 3 (subtract with borrow) gives acc-opb-CY, both modulo 256. The carry flag is set exactly when the unsigned subtrahend (including the borrow) exceeds acc.
- R3: The auxiliary carry (flags_o bit 1) is the carry out of the low nibble on add and add-with-carry (0x0F+0x08 gives 0x17 with AC=1). On subtract and subtract-with-borrow it is the borrow into the low nibble.
- R4: For arithmetic and logic opcodes, S (flags_o bit 4) equals result bit 7, Z (bit 3) is 1 when the result is 0x00, and P (bit 2) is 1 when the result holds an even number of 1 bits.
- R5: Opcode 4 (increment) gives acc+1 and opcode 5 (decrement) gives acc-1, both wrapping. They update S, Z, P and AC (nibble carry or nibble borrow) and leave CY (flags_o bit 0) unchanged.
- R6: Opcodes 6 (AND), 7 (OR), 8 (XOR) and 9 (complement of acc, opb ignored) give the bitwise result, clear CY and AC, and update S, Z and P.
- R7: Opcodes 10 to 13 rotate acc by one place: 10 left circular, 11 right circular, 12 left through CY, 13 right through CY. CY takes the bit shifted out, and S, Z, P and AC keep their values.
- R8: The flags change only on a rising clock edge with flag_we_i high. With flag_we_i low they hold, whatever the opcode.
- R9: A synchronous reset (rst_n low at a clock edge) clears all five flags to 0.
- R10: Opcodes 14 and 15 are unassigned. They pass acc to the result and leave all flags unchanged even with flag_we_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | DATA_W | Accumulator operand |
| opb_i | input | DATA_W | Second operand |
| flag_we_i | input | 1 | Flag-write enable, sampled at the clock edge |
| result_o | output | DATA_W | Combinational result |
| flags_o | output | 5 | Stored flags {S, Z, P, AC, CY} |

## Verification
The bench builds the block with its default DATA_W of 8 and its fixed four-bit nibble. At that width, byte-sized vectors reach the wrap points 0xFF+1 and 0x00-1, the 0x0F/0x10 nibble boundary and the sign bit directly. Chained operations carry the stored CY into add-with-carry, subtract-with-borrow and the rotates through carry. This checks that the flag register and the operation mask agree across consecutive cycles.

// File: rtl/byte_alu_pkg.sv
// Package: shared operation codes and flag bit positions for the byte ALU.
// Assumes a four-bit operation code. Flag positions are part of the port contract.
package byte_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_NOT  = 4'd9,
        OP_RLC  = 4'd10,
        OP_RRC  = 4'd11,
        OP_RAL  = 4'd12,
        OP_RAR  = 4'd13,
        OP_RS14 = 4'd14,
        OP_RS15 = 4'd15
    } alu_op_e;

    localparam int FLAG_N = 5;
    localparam int FLG_CY = 0;
    localparam int FLG_AC = 1;
    localparam int FLG_P  = 2;
    localparam int FLG_Z  = 3;
    localparam int FLG_S  = 4;

endpackage

// File: rtl/byte_alu_addsub.sv
// Module: shared adder/subtracter with a nibble-boundary carry tap.
// Subtraction is done as a + ~b + ~borrow. The carry and aux outputs are
// inverted in that case so that they report borrows. Assumes NIB_W < DATA_W.
module byte_alu_addsub #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              aux_o
);
    logic [DATA_W-1:0] b_eff;
    logic              c0;
    logic [DATA_W:0]   full_sum;
    logic [NIB_W:0]    low_sum;

    // Condition the second operand and the carry-in for add or subtract.
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c0    = sub_i ^ cin_i;
    end

    // Full-width and low-nibble sums. The nibble sum yields the aux carry.
    always_comb begin
        full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c0};
        low_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, c0};
    end

    // Present the sum and the carries, turned into borrows on subtraction.
    always_comb begin
        sum_o   = full_sum[DATA_W-1:0];
        carry_o = full_sum[DATA_W] ^ sub_i;
        aux_o   = low_sum[NIB_W] ^ sub_i;
    end
endmodule

// File: rtl/byte_alu_logic.sv
// Module: bitwise unit (AND, OR, XOR, complement of a).
// sel_i: 0 AND, 1 OR, 2 XOR, 3 NOT a. Purely combinational.
module byte_alu_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [1:0]        sel_i,
    output logic [DATA_W-1:0] y_o
);
    // Select the bitwise function.
    always_comb begin
        unique case (sel_i)
            2'd0:    y_o = a_i & b_i;
            2'd1:    y_o = a_i | b_i;
            2'd2:    y_o = a_i ^ b_i;
            default: y_o = ~a_i;
        endcase
    end
endmodule

// File: rtl/byte_alu_rotate.sv
// Module: one-place rotator, left or right, circular or through the carry.
// carry_o is the bit shifted out of the operand in every mode.
module byte_alu_rotate #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic              cy_i,
    input  logic              right_i,
    input  logic              thru_i,
    output logic [DATA_W-1:0] y_o,
    output logic              carry_o
);
    logic fill;

    // Pick the bit that enters the vacated end.
    always_comb begin
        if (thru_i)       fill = cy_i;
        else if (right_i) fill = a_i[0];
        else              fill = a_i[DATA_W-1];
    end

    // Shift by one place and report the bit that leaves.
    always_comb begin
        if (right_i) begin
            y_o     = {fill, a_i[DATA_W-1:1]};
            carry_o = a_i[0];
        end else begin
            y_o     = {a_i[DATA_W-2:0], fill};
            carry_o = a_i[DATA_W-1];
        end
    end
endmodule

// File: rtl/byte_alu_flagreg.sv
// Module: status flag register with a write mask per flag.
// A flag loads only when the enable and its mask bit are both high.
// Synchronous active-low reset clears every flag.
module byte_alu_flagreg #(
    parameter int FLAG_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [FLAG_N-1:0] mask_i,
    input  logic [FLAG_N-1:0] d_i,
    output logic [FLAG_N-1:0] q_o
);
    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        // Hold or load one flag bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                  q_o[g] <= 1'b0;
            else if (we_i && mask_i[g]) q_o[g] <= d_i[g];
        end
    end
endmodule

// File: rtl/byte_alu_top.sv
// Module: byte ALU top. It gives a combinational result from op_i/acc_i/opb_i
// and a registered flag set {S,Z,P,AC,CY} that is written under flag_we_i.
// Assumes DATA_W > 4. The aux carry is always taken at the 4-bit boundary.
module byte_alu_top
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              flag_we_i,
    output logic [DATA_W-1:0] result_o,
    output logic [4:0]        flags_o
);
    localparam int NIB_W = 4;

    alu_op_e           op;
    logic [DATA_W-1:0] as_b;
    logic              as_sub, as_cin;
    logic [DATA_W-1:0] as_sum;
    logic              as_cy, as_ac;
    logic [DATA_W-1:0] lg_y;
    logic [DATA_W-1:0] rt_y;
    logic              rt_cy;
    logic [FLAG_N-1:0] flag_q, flag_d, flag_mask;

    // Interpret the raw opcode.
    always_comb op = alu_op_e'(op_i);

    // Set up the adder for the arithmetic opcodes.
    always_comb begin
        as_b   = opb_i;
        as_sub = 1'b0;
        as_cin = 1'b0;
        unique case (op)
            OP_ADC: as_cin = flag_q[FLG_CY];
            OP_SUB: as_sub = 1'b1;
            OP_SBB: begin as_sub = 1'b1; as_cin = flag_q[FLG_CY]; end
            OP_INC: begin as_b = '0; as_cin = 1'b1; end
            OP_DEC: begin as_b = '0; as_sub = 1'b1; as_cin = 1'b1; end
            default: ;
        endcase
    end

    byte_alu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
        .a_i(acc_i), .b_i(as_b), .sub_i(as_sub), .cin_i(as_cin),
        .sum_o(as_sum), .carry_o(as_cy), .aux_o(as_ac)
    );

    byte_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i(acc_i), .b_i(opb_i), .sel_i(op_i[1:0] - 2'd2), .y_o(lg_y)
    );

    byte_alu_rotate #(.DATA_W(DATA_W)) u_rotate (
        .a_i(acc_i), .cy_i(flag_q[FLG_CY]), .right_i(op_i[0]),
        .thru_i(op_i[2]), .y_o(rt_y), .carry_o(rt_cy)
    );

    // Steer the result and the per-flag write mask by operation group.
    always_comb begin
        result_o  = acc_i;
        flag_mask = '0;
        flag_d    = flag_q;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                result_o  = as_sum;
                flag_mask = 5'b11111;
                flag_d[FLG_CY] = as_cy;
                flag_d[FLG_AC] = as_ac;
            end
            OP_INC, OP_DEC: begin
                result_o  = as_sum;
                flag_mask = 5'b11110;
                flag_d[FLG_AC] = as_ac;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                result_o  = lg_y;
                flag_mask = 5'b11111;
                flag_d[FLG_CY] = 1'b0;
                flag_d[FLG_AC] = 1'b0;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                result_o  = rt_y;
                flag_mask = 5'b00001;
                flag_d[FLG_CY] = rt_cy;
            end
            default: ;
        endcase
        flag_d[FLG_S] = result_o[DATA_W-1];
        flag_d[FLG_Z] = (result_o == '0);
        flag_d[FLG_P] = ~^result_o;
    end

    byte_alu_flagreg #(.FLAG_N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .we_i(flag_we_i),
        .mask_i(flag_mask), .d_i(flag_d), .q_o(flag_q)
    );

    // Drive the stored flags out.
    always_comb flags_o = flag_q;
endmodule

// File: rtl/byte_alu_chk.sv
// Checker: temporal properties of the byte ALU, observed at its ports.
module byte_alu_chk
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic              flag_we_i,
    input logic [DATA_W-1:0] result_o,
    input logic [4:0]        flags_o
);
    logic is_arlg, is_incdec, is_logic, is_rot, is_rsv;

    // Group the opcodes for the properties.
    always_comb begin
        is_incdec = (op_i == OP_INC) || (op_i == OP_DEC);
        is_logic  = (op_i >= OP_AND) && (op_i <= OP_NOT);
        is_rot    = (op_i >= OP_RLC) && (op_i <= OP_RAR);
        is_rsv    = (op_i >= OP_RS14);
        is_arlg   = !is_rot && !is_rsv;
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> flags_o == 5'b0);

    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(flags_o));

    // R4
    szp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && is_arlg) |=>
        (flags_o[FLG_P] == ~^$past(result_o)) &&
        (flags_o[FLG_Z] == ($past(result_o) == '0)) &&
        (flags_o[FLG_S] == $past(result_o[DATA_W-1])));

    // R5
    incdec_keep_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && is_incdec) |=> flags_o[FLG_CY] == $past(flags_o[FLG_CY]));

    // R6
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && is_logic) |=> !flags_o[FLG_CY] && !flags_o[FLG_AC]);

    // R7
    rot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && is_rot) |=> flags_o[4:1] == $past(flags_o[4:1]));

    // R10
    rsv_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rsv |-> result_o == acc_i);

    // R10
    rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rsv |=> $stable(flags_o));
endmodule

bind byte_alu_top byte_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
    .flag_we_i(flag_we_i), .result_o(result_o), .flags_o(flags_o)
);

// File: tb/byte_alu_top_tb.sv
// Directed bench for byte_alu_top: one task per scenario, with a flag model kept here.
module byte_alu_top_tb;
    import byte_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] acc = 8'd0, opb = 8'd0;
    logic       we = 1'b0;
    logic [7:0] res;
    logic [4:0] flg;
    logic [4:0] mflags = 5'd0;
    int runs = 0, fails = 0;

    byte_alu_top #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc), .opb_i(opb),
        .flag_we_i(we), .result_o(res), .flags_o(flg)
    );

    always #5 clk = ~clk;

    // Expected result and flags from the requirement text.
    function automatic void model(input logic [3:0] o, input logic [7:0] a, b,
                                  input logic [4:0] fi,
                                  output logic [7:0] r, output logic [4:0] fo);
        logic [8:0] s;
        logic cy, ac, upd;
        cy = fi[0]; ac = fi[1]; upd = 1'b1; r = a;
        case (o)
            OP_ADD: begin s = {1'b0, a} + {1'b0, b}; r = s[7:0]; cy = s[8];
                          ac = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15; end
            OP_ADC: begin s = {1'b0, a} + {1'b0, b} + {8'd0, fi[0]}; r = s[7:0]; cy = s[8];
                          ac = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, fi[0]}) > 5'd15; end
            OP_SUB: begin r = a - b; cy = b > a; ac = b[3:0] > a[3:0]; end
            OP_SBB: begin r = a - b - {7'd0, fi[0]};
                          cy = ({1'b0, b} + {8'd0, fi[0]}) > {1'b0, a};
                          ac = ({1'b0, b[3:0]} + {4'd0, fi[0]}) > {1'b0, a[3:0]}; end
            OP_INC: begin r = a + 8'd1; ac = (a[3:0] == 4'hF); end
            OP_DEC: begin r = a - 8'd1; ac = (a[3:0] == 4'h0); end
            OP_AND: begin r = a & b; cy = 0; ac = 0; end
            OP_OR:  begin r = a | b; cy = 0; ac = 0; end
            OP_XOR: begin r = a ^ b; cy = 0; ac = 0; end
            OP_NOT: begin r = ~a; cy = 0; ac = 0; end
            OP_RLC: begin r = {a[6:0], a[7]}; cy = a[7]; upd = 0; end
            OP_RRC: begin r = {a[0], a[7:1]}; cy = a[0]; upd = 0; end
            OP_RAL: begin r = {a[6:0], fi[0]}; cy = a[7]; upd = 0; end
            OP_RAR: begin r = {fi[0], a[7:1]}; cy = a[0]; upd = 0; end
            default: upd = 0;
        endcase
        fo = upd ? {r[7], r == 8'd0, ~^r, ac, cy} : {fi[4:2], ac, cy};
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Apply one operation, check the combinational result, then the flags after the edge.
    task automatic run(input string tag, input logic [3:0] o, input logic [7:0] a, b,
                       input logic w);
        logic [7:0] er;
        logic [4:0] ef;
        @(negedge clk);
        op = o; acc = a; opb = b; we = w;
        model(o, a, b, mflags, er, ef);
        #1 check(tag, "result", res, er);
        @(negedge clk);
        if (w) mflags = ef;
        check(tag, "flags", {3'd0, flg}, {3'd0, mflags});
        we = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; mflags = 5'd0;
        check("R9", "flags after reset", {3'd0, flg}, 8'd0);
    endtask

    task automatic t_add;
        run("R1", OP_ADD, 8'h12, 8'h34, 1);
        run("R1", OP_ADD, 8'hF0, 8'h20, 1);
        run("R1", OP_ADC, 8'h01, 8'h01, 1);
        run("R1", OP_ADC, 8'hFF, 8'h00, 1);
    endtask

    task automatic t_sub;
        run("R2", OP_SUB, 8'h50, 8'h20, 1);
        run("R2", OP_SUB, 8'h20, 8'h50, 1);
        run("R2", OP_SBB, 8'h10, 8'h05, 1);
        run("R2", OP_SUB, 8'h05, 8'h05, 1);
        run("R2", OP_SBB, 8'h05, 8'h05, 1);
    endtask

    task automatic t_aux;
        run("R3", OP_ADD, 8'h0F, 8'h08, 1);
        check("R3", "0x0F+0x08 flags", {3'd0, flg}, 8'b0000_0110);
        run("R3", OP_SUB, 8'h10, 8'h01, 1);
        run("R3", OP_SUB, 8'h1F, 8'h01, 1);
    endtask

    task automatic t_szp;
        run("R4", OP_ADD, 8'h7F, 8'h01, 1);
        check("R4", "S set on 0x80", {7'd0, flg[4]}, 8'd1);
        run("R4", OP_ADD, 8'h80, 8'h80, 1);
        check("R4", "Z set on zero", {7'd0, flg[3]}, 8'd1);
        run("R4", OP_OR, 8'h01, 8'h02, 1);
        check("R4", "P on 0x03", {7'd0, flg[2]}, 8'd1);
        run("R4", OP_OR, 8'h07, 8'h00, 1);
        check("R4", "P on 0x07", {7'd0, flg[2]}, 8'd0);
    endtask

    task automatic t_incdec;
        run("R5", OP_ADD, 8'hFF, 8'h01, 1);
        run("R5", OP_INC, 8'h0F, 8'h00, 1);
        check("R5", "CY kept after INC", {7'd0, flg[0]}, 8'd1);
        run("R5", OP_INC, 8'hFF, 8'h00, 1);
        run("R5", OP_DEC, 8'h00, 8'h00, 1);
        run("R5", OP_AND, 8'h00, 8'h00, 1);
        run("R5", OP_DEC, 8'h01, 8'h00, 1);
        check("R5", "CY stays clear after DEC", {7'd0, flg[0]}, 8'd0);
    endtask

    task automatic t_logic;
        run("R6", OP_SUB, 8'h00, 8'h01, 1);
        run("R6", OP_AND, 8'hF3, 8'h3C, 1);
        run("R6", OP_SUB, 8'h00, 8'h01, 1);
        run("R6", OP_XOR, 8'hAA, 8'hAA, 1);
        run("R6", OP_NOT, 8'h5A, 8'hFF, 1);
        run("R6", OP_OR, 8'h80, 8'h01, 1);
    endtask

    task automatic t_rotate;
        run("R7", OP_SUB, 8'h00, 8'h01, 1);
        run("R7", OP_RLC, 8'h81, 8'h00, 1);
        run("R7", OP_RRC, 8'h02, 8'h00, 1);
        run("R7", OP_RAL, 8'h40, 8'h00, 1);
        run("R7", OP_RAL, 8'h80, 8'h00, 1);
        run("R7", OP_RAR, 8'h00, 8'h00, 1);
        run("R7", OP_RAR, 8'h01, 8'h00, 1);
    endtask

    task automatic t_hold;
        run("R8", OP_ADD, 8'h0F, 8'hF1, 1);
        run("R8", OP_SUB, 8'h00, 8'h01, 0);
        run("R8", OP_NOT, 8'h00, 8'h00, 0);
        run("R8", OP_RRC, 8'h00, 8'h00, 0);
    endtask

    task automatic t_rsv;
        run("R10", OP_SUB, 8'h00, 8'h11, 1);
        run("R10", OP_RS14, 8'h3C, 8'hFF, 1);
        run("R10", OP_RS15, 8'h00, 8'h00, 1);
    endtask

    task automatic t_reset_mid;
        run("R9", OP_SUB, 8'h00, 8'h01, 1);
        t_reset();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; runs++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_aux();
        t_szp();
        t_incdec();
        t_logic();
        t_rotate();
        t_hold();
        t_rsv();
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule